// File: doc/BRIEF.md
# Power Button Hold Override Controller

This block watches an active-low power button and keeps two sticky status bits: a press status that records each new press, and an override status that records a forced shutdown. A press sets the press status whatever any enable says. When the button stays low for a programmed number of timebase ticks, the block turns the pending press into an override. It clears the press status, sets the override status and sends one-cycle requests to the power sequencer. Those requests force the soft-off state, arm the restore-after-power-loss enable, and restrict wake sources to the power button alone.

A management bus message, a management-controller request and a catastrophic thermal trip can also raise an override. Software clears either status bit by pulsing its write-1-to-clear strobe. Two resets reach the block. The hard reset leaves both status bits untouched. The resume-well reset clears the press status but not the override status, so the override status survives a power failure.

Top module: `pwrbtn_override_ctrl`

## Requirements
- R1: A high-to-low transition on `btn_n`, after the two-flop synchroniser, sets `press_sts` within four clock cycles, with no enable involved.
- R2: Holding `btn_n` low for `HOLD_TICKS` consecutive `tick` pulses sets `ovr_sts` and clears `press_sts`.
- R3: Each override event gives exactly one single-cycle pulse on `s5_req`, on `afterloss_set` and on `wake_btn_only`, all in the same cycle. Holding the button longer gives no further pulse.
- R4: A rising edge on `ovr_bus_msg`, `ovr_mgmt` or `thermal_trip` sets `ovr_sts` and gives one override pulse set per edge, however long the input stays high.
- R5: A one-cycle pulse on `w1c_press` clears only `press_sts`, and a pulse on `w1c_ovr` clears only `ovr_sts`. With the strobes held low, both bits keep their value.
- R6: If `press_sts` is cleared while the button is still held low, it stays clear until the button is released and pressed again. The button release also leaves it clear.
- R7: Asserting `rst_hard` changes neither `press_sts` nor `ovr_sts`.
- R8: Asserting `rst_rsm` clears `press_sts` and leaves `ovr_sts` unchanged.
- R9: Releasing the button restarts the hold count. Several short presses, each shorter than the hold time, never cause an override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_hard | input | 1 | Synchronous hard reset, active high; status bits kept |
| rst_rsm | input | 1 | Synchronous resume-well reset, active high; clears press status |
| btn_n | input | 1 | Asynchronous power button, low = pressed |
| tick | input | 1 | One-cycle timebase pulse for hold counting |
| w1c_press | input | 1 | Write-1-to-clear strobe for the press status |
| w1c_ovr | input | 1 | Write-1-to-clear strobe for the override status |
| ovr_bus_msg | input | 1 | Override request from a management bus message |
| ovr_mgmt | input | 1 | Override or reset-with-power-down request from the management controller |
| thermal_trip | input | 1 | Catastrophic thermal condition |
| press_sts | output | 1 | Sticky press status |
| ovr_sts | output | 1 | Sticky override status |
| s5_req | output | 1 | One-cycle request to force soft-off |
| afterloss_set | output | 1 | One-cycle request to set the after-power-loss enable |
| wake_btn_only | output | 1 | One-cycle request to leave only the button as wake source |

## Verification
The bench clears the press status while the button is still held. A design that re-armed on level instead of edge would set the bit again at once. It then keeps the button down well past the hold time and counts the override pulses. A timer that restarted after firing would send soft-off requests repeatedly. Split presses whose total time exceeds the hold time expose a counter that does not restart on release. The bench asserts each reset with both bits set, which catches any status bit wired to the wrong reset.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  // one bit per external override source
  typedef struct packed {
    logic thermal;
    logic mgmt;
    logic bus;
  } ovr_src_t;
  localparam int unsigned NUM_EXT_SRC = $bits(ovr_src_t);
endpackage

// File: rtl/pbo_sync.sv
module pbo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_n,
  output logic low_o
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= ~din_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], ~din_n};
      end
    end
  endgenerate

  assign low_o = sr[STAGES-1];
endmodule

// File: rtl/pbo_edge.sv
module pbo_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/pbo_hold_timer.sv
module pbo_hold_timer #(
  parameter int unsigned HOLD_TICKS = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic held,
  output logic fire
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst || !held) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (tick && !done) begin
        if (cnt == LAST) begin
          fire <= 1'b1;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: one hold gives a single fire pulse
  p_fire_single_r3: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  // R9: a fire only follows a cycle where the button was held
  p_fire_needs_hold_r9: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(held));
endmodule

// File: rtl/pwrbtn_override_ctrl.sv
module pwrbtn_override_ctrl #(
  parameter int unsigned HOLD_TICKS  = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_hard,
  input  logic rst_rsm,
  input  logic btn_n,
  input  logic tick,
  input  logic w1c_press,
  input  logic w1c_ovr,
  input  logic ovr_bus_msg,
  input  logic ovr_mgmt,
  input  logic thermal_trip,
  output logic press_sts,
  output logic ovr_sts,
  output logic s5_req,
  output logic afterloss_set,
  output logic wake_btn_only
);
  import pbo_pkg::*;

  logic     rst_any;
  logic     btn_low;
  logic     btn_fall;
  logic     hold_fire;
  ovr_src_t ext_lvl;
  ovr_src_t ext_rise;
  logic     ovr_evt;

  logic press_q;
  logic ovr_q = 1'b0;   // no reset: kept across power loss
  logic s5_q, afl_q, wk_q;

  assign rst_any = rst_hard | rst_rsm;
  assign ext_lvl = '{thermal: thermal_trip, mgmt: ovr_mgmt, bus: ovr_bus_msg};

  pbo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst_any), .din_n(btn_n), .low_o(btn_low)
  );

  pbo_edge #(.W(1)) u_btn_edge (
    .clk(clk), .rst(rst_any), .lvl(btn_low), .rise(btn_fall)
  );

  pbo_edge #(.W(NUM_EXT_SRC)) u_ext_edge (
    .clk(clk), .rst(rst_any), .lvl(ext_lvl), .rise(ext_rise)
  );

  pbo_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk(clk), .rst(rst_any), .tick(tick), .held(btn_low), .fire(hold_fire)
  );

  assign ovr_evt = hold_fire | (|ext_rise);

  // press status: resume reset only; hold override beats a new edge beats clear
  always_ff @(posedge clk) begin
    if (rst_rsm)        press_q <= 1'b0;
    else if (hold_fire) press_q <= 1'b0;
    else if (btn_fall)  press_q <= 1'b1;
    else if (w1c_press) press_q <= 1'b0;
  end

  // override status: no reset input affects it
  always_ff @(posedge clk) begin
    if (ovr_evt)      ovr_q <= 1'b1;
    else if (w1c_ovr) ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      s5_q  <= 1'b0;
      afl_q <= 1'b0;
      wk_q  <= 1'b0;
    end else begin
      s5_q  <= ovr_evt;
      afl_q <= ovr_evt;
      wk_q  <= ovr_evt;
    end
  end

  assign press_sts     = press_q;
  assign ovr_sts       = ovr_q;
  assign s5_req        = s5_q;
  assign afterloss_set = afl_q;
  assign wake_btn_only = wk_q;

  // R1: a synchronised press edge lands in the status bit
  p_press_edge_r1: assert property (@(posedge clk) disable iff (rst_any)
    (btn_fall && !hold_fire) |=> press_sts);
  // R2: a completed hold leaves the press status clear
  p_hold_clears_press_r2: assert property (@(posedge clk) disable iff (rst_any)
    hold_fire |=> (!press_sts && ovr_sts));
  // R3: every soft-off request comes with the override status
  p_s5_has_status_r3: assert property (@(posedge clk) disable iff (rst_any)
    s5_req |-> ovr_sts);
  // R5: without a clear strobe the override status stays set
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (rst_rsm)
    (ovr_sts && !w1c_ovr) |=> ovr_sts);
endmodule

// File: tb/pwrbtn_override_ctrl_test.sv
module pwrbtn_override_ctrl_test;
  localparam int unsigned HT = 6;

  logic clk = 1'b0;
  logic rst_hard = 1'b0, rst_rsm = 1'b1;
  logic btn_n = 1'b1, tick = 1'b0;
  logic w1c_press = 1'b0, w1c_ovr = 1'b0;
  logic ovr_bus_msg = 1'b0, ovr_mgmt = 1'b0, thermal_trip = 1'b0;
  logic press_sts, ovr_sts, s5_req, afterloss_set, wake_btn_only;

  int checks = 0, errors = 0;
  int pulses = 0, mismatch = 0;
  int tdiv = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwrbtn_override_ctrl #(.HOLD_TICKS(HT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_hard(rst_hard), .rst_rsm(rst_rsm), .btn_n(btn_n),
    .tick(tick), .w1c_press(w1c_press), .w1c_ovr(w1c_ovr),
    .ovr_bus_msg(ovr_bus_msg), .ovr_mgmt(ovr_mgmt), .thermal_trip(thermal_trip),
    .press_sts(press_sts), .ovr_sts(ovr_sts), .s5_req(s5_req),
    .afterloss_set(afterloss_set), .wake_btn_only(wake_btn_only)
  );

  // timebase: one tick every four cycles
  always @(negedge clk) begin
    tick = (tdiv == 3);
    tdiv = (tdiv + 1) % 4;
  end

  // pulse monitor for R3
  always @(negedge clk) begin
    if (s5_req) pulses++;
    if ((s5_req != afterloss_set) || (s5_req != wake_btn_only)) mismatch++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_press();
    w1c_press = 1'b1; cyc(1); w1c_press = 1'b0; cyc(2);
  endtask

  task automatic strobe_ovr();
    w1c_ovr = 1'b1; cyc(1); w1c_ovr = 1'b0; cyc(2);
  endtask

  task automatic t_reset_state();
    check("R8 reset press", press_sts, 0);
    check("R8 reset ovr", ovr_sts, 0);
    check("R3 reset s5", s5_req, 0);
  endtask

  task automatic t_press_and_clear();
    btn_n = 1'b0; cyc(5);
    check("R1 press sets", press_sts, 1);
    strobe_ovr();
    check("R5 ovr strobe keeps press", press_sts, 1);
    strobe_press();
    check("R6 cleared while held", press_sts, 0);
    cyc(2);
    check("R6 stays clear while held", press_sts, 0);
    btn_n = 1'b1; cyc(5);
    check("R6 release leaves clear", press_sts, 0);
    btn_n = 1'b0; cyc(5);
    check("R6 re-press sets", press_sts, 1);
    btn_n = 1'b1; cyc(8);
    check("R5 no strobe keeps press", press_sts, 1);
    strobe_press();
    check("R5 press strobe clears", press_sts, 0);
  endtask

  task automatic t_split_presses();
    int p0 = pulses;
    for (int i = 0; i < 3; i++) begin
      btn_n = 1'b0; cyc(16);
      btn_n = 1'b1; cyc(6);
    end
    check("R9 short presses no override", ovr_sts, 0);
    check("R9 short presses no pulse", pulses - p0, 0);
    strobe_press();
  endtask

  task automatic t_long_hold();
    int p0 = pulses;
    btn_n = 1'b0; cyc(5);
    check("R1 press before hold", press_sts, 1);
    cyc(HT * 4 + 8);
    check("R2 override set", ovr_sts, 1);
    check("R2 press cleared", press_sts, 0);
    check("R3 one pulse", pulses - p0, 1);
    cyc(HT * 4 * 3);
    check("R3 no repeat while held", pulses - p0, 1);
    check("R6 press stays clear after hold", press_sts, 0);
    btn_n = 1'b1; cyc(5);
    check("R6 release after hold", press_sts, 0);
    btn_n = 1'b0; cyc(5); btn_n = 1'b1; cyc(4);
    check("R1 re-armed after hold", press_sts, 1);
  endtask

  task automatic t_resets();
    check("R7 precondition ovr", ovr_sts, 1);
    rst_hard = 1'b1; cyc(3); rst_hard = 1'b0; cyc(2);
    check("R7 hard keeps press", press_sts, 1);
    check("R7 hard keeps ovr", ovr_sts, 1);
    rst_rsm = 1'b1; cyc(3); rst_rsm = 1'b0; cyc(2);
    check("R8 resume clears press", press_sts, 0);
    check("R8 resume keeps ovr", ovr_sts, 1);
    strobe_ovr();
    check("R5 ovr strobe clears", ovr_sts, 0);
  endtask

  task automatic t_ext_source(input int which);
    int p0 = pulses;
    case (which)
      0: ovr_bus_msg = 1'b1;
      1: ovr_mgmt = 1'b1;
      default: thermal_trip = 1'b1;
    endcase
    cyc(10);
    check("R4 ext sets ovr", ovr_sts, 1);
    check("R4 one pulse per edge", pulses - p0, 1);
    ovr_bus_msg = 1'b0; ovr_mgmt = 1'b0; thermal_trip = 1'b0;
    cyc(2);
    strobe_ovr();
    check("R4 cleared after ext", ovr_sts, 0);
  endtask

  initial begin
    cyc(4);
    rst_rsm = 1'b0;
    cyc(2);
    t_reset_state();
    t_press_and_clear();
    t_split_presses();
    t_long_hold();
    t_resets();
    for (int s = 0; s < 3; s++) t_ext_source(s);
    check("R3 pulses aligned", mismatch, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule